// File: doc/BRIEF.md
# General-Purpose Pin Bank Register Block

This block holds the control state for a bank of up to 32 general-purpose pins and makes it reachable through a plain 32-bit word register port: an address, a write strobe with write data, and a read strobe with registered read data. Each pin has four controls. A mode bit hands the pin either to plain I/O or to an interrupt sensing block elsewhere. A direction bit selects input or output. An output data bit sets the level the pin drives. A polarity bit inverts the sensed level. The block drives the pin output levels and output enables. It passes pin inputs through a two-flop synchronizer and applies the polarity bit before the level is read back or handed to the interrupt logic.

Software preloads the output level and then flips the direction bit, so the pin never drives a stale value. Pins in interrupt mode are never driven, whatever their direction bit holds. Their polarity-corrected level and their mode bit are presented to the neighbouring interrupt detector. A parameter fixes how many pins the bank really has. The bits above that count hold nothing and always read as zero.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every register is zero: no pin is driven (`pin_oe` = 0, `pin_out` = 0), every pin is an input in plain I/O mode with positive logic, and every register reads as zero.
- R2: Direction register at byte offset 0x04: a 1 in bit n makes pin n an output, and `pin_oe[n]` is 1 exactly when that bit is 1 and the pin's mode bit is 0.
- R3: Mode register at byte offset 0x00: a 1 in bit n puts pin n in interrupt mode. Its output enable is then forced low, and the bit appears on `int_sel[n]`.
- R4: Output data register at byte offset 0x08 reads back exactly what was last written (within the pin count). It drives `pin_out` from the cycle after the write, whether or not the pin is enabled.
- R5: Input data register at byte offset 0x0C returns, for pins that are not enabled outputs, the pin level seen through a two-flop synchronizer XOR the polarity bit. `int_lvl` carries the same corrected level for every pin.
- R6: For a pin whose output enable is active, the input data register returns the output data bit rather than the pin level.
- R7: Polarity register at byte offset 0x20: bit n = 1 inverts pin n's sensed level, 0 passes it unchanged.
- R8: Register bits at or above PIN_COUNT cannot be set and always read as zero.
- R9: Reads of any other address (including non-aligned ones) return zero. Writes to those addresses, or to the read-only input data offset, change no register.
- R10: `rdata` is loaded on the clock edge where `rd_en` is high, so it is valid from the next cycle, and it holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Raw asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output levels to the pads |
| pin_oe | output | PIN_COUNT | Output enables to the pads |
| int_sel | output | PIN_COUNT | Per-pin interrupt-mode select for the interrupt detector |
| int_lvl | output | PIN_COUNT | Synchronized, polarity-corrected pin levels |

## Verification
The bench sweeps every direction value against a fixed interrupt-mode pattern. A design that let interrupt-mode pins drive would show enables where none are allowed. It sweeps every input pattern under three polarity masks, so a missing or per-bit-wrong inversion shows up in the input readback. It mixes output and input pins in one read: a design that always read the pad, or that took output values for interrupt-mode pins, returns the wrong word. It also writes all ones to every register, writes to unmapped and read-only offsets, and changes state between reads. This catches bits kept above the pin count, stray decodes that corrupt a register, and a read port that is transparent instead of held.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BUS_ADDR_W = 8;
  localparam int unsigned BUS_DATA_W = 32;
  localparam int unsigned MAX_PINS   = 32;

  localparam logic [BUS_ADDR_W-1:0] OFF_MODE = 8'h00;
  localparam logic [BUS_ADDR_W-1:0] OFF_DIR  = 8'h04;
  localparam logic [BUS_ADDR_W-1:0] OFF_OUT  = 8'h08;
  localparam logic [BUS_ADDR_W-1:0] OFF_IN   = 8'h0C;
  localparam logic [BUS_ADDR_W-1:0] OFF_POL  = 8'h20;

  typedef struct packed {
    logic mode;
    logic dir;
    logic dout;
    logic pol;
  } wr_sel_t;

  function automatic wr_sel_t decode_write(input logic en,
                                           input logic [BUS_ADDR_W-1:0] a);
    wr_sel_t s;
    s.mode = en && (a == OFF_MODE);
    s.dir  = en && (a == OFF_DIR);
    s.dout = en && (a == OFF_OUT);
    s.pol  = en && (a == OFF_POL);
    return s;
  endfunction

endpackage

// File: rtl/gpio_bank_rst_sync.sv
module gpio_bank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_in_sync.sv
module gpio_bank_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= raw_in[g];
        stable_q <= meta_q;
      end
    end

    assign sync_out[g] = stable_q;
  end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  wr_sel_t               wr_sel,
  input  logic [BUS_DATA_W-1:0] wdata,
  output logic [PINS-1:0]       mode_q,
  output logic [PINS-1:0]       dir_q,
  output logic [PINS-1:0]       dout_q,
  output logic [PINS-1:0]       pol_q
);

  logic [PINS-1:0] wval;
  logic [PINS-1:0] mode_d;
  logic [PINS-1:0] dir_d;
  logic [PINS-1:0] dout_d;
  logic [PINS-1:0] pol_d;

  assign wval = wdata[PINS-1:0];

  always_comb begin
    mode_d = wr_sel.mode ? wval : mode_q;
    dir_d  = wr_sel.dir  ? wval : dir_q;
    dout_d = wr_sel.dout ? wval : dout_q;
    pol_d  = wr_sel.pol  ? wval : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '0;
    end else begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      dout_q <= dout_d;
      pol_q  <= pol_d;
    end
  end

endmodule

// File: rtl/gpio_bank_rdport.sv
module gpio_bank_rdport
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [PINS-1:0]       mode_q,
  input  logic [PINS-1:0]       dir_q,
  input  logic [PINS-1:0]       dout_q,
  input  logic [PINS-1:0]       pol_q,
  input  logic [PINS-1:0]       in_view,
  output logic [BUS_DATA_W-1:0] rdata
);

  logic [PINS-1:0]       sel_word;
  logic [BUS_DATA_W-1:0] rd_d;
  logic [BUS_DATA_W-1:0] rd_q;

  always_comb begin
    unique case (addr)
      OFF_MODE: sel_word = mode_q;
      OFF_DIR:  sel_word = dir_q;
      OFF_OUT:  sel_word = dout_q;
      OFF_IN:   sel_word = in_view;
      OFF_POL:  sel_word = pol_q;
      default:  sel_word = '0;
    endcase
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = '0;
      rd_d[PINS-1:0] = sel_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic                  wr_en,
  input  logic [BUS_DATA_W-1:0] wdata,
  input  logic                  rd_en,
  output logic [BUS_DATA_W-1:0] rdata,
  input  logic [PIN_COUNT-1:0]  pin_in,
  output logic [PIN_COUNT-1:0]  pin_out,
  output logic [PIN_COUNT-1:0]  pin_oe,
  output logic [PIN_COUNT-1:0]  int_sel,
  output logic [PIN_COUNT-1:0]  int_lvl
);

  localparam int unsigned PINS = (PIN_COUNT == 0) ? 1 :
                                 (PIN_COUNT > MAX_PINS) ? MAX_PINS : PIN_COUNT;

  logic            rst_int_n;
  wr_sel_t         wr_sel;
  logic [PINS-1:0] mode_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] dout_q;
  logic [PINS-1:0] pol_q;
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] sensed;
  logic [PINS-1:0] drive_en;
  logic [PINS-1:0] in_view;

  gpio_bank_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign wr_sel = decode_write(wr_en, addr);

  gpio_bank_regfile #(.PINS(PINS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_sel (wr_sel),
    .wdata  (wdata),
    .mode_q (mode_q),
    .dir_q  (dir_q),
    .dout_q (dout_q),
    .pol_q  (pol_q)
  );

  gpio_bank_in_sync #(.WIDTH(PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .raw_in   (pin_in),
    .sync_out (pin_sync)
  );

  always_comb begin
    sensed   = pin_sync ^ pol_q;
    drive_en = dir_q & ~mode_q;
    in_view  = (drive_en & dout_q) | (~drive_en & sensed);
  end

  gpio_bank_rdport #(.PINS(PINS)) u_rd (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .mode_q  (mode_q),
    .dir_q   (dir_q),
    .dout_q  (dout_q),
    .pol_q   (pol_q),
    .in_view (in_view),
    .rdata   (rdata)
  );

  assign pin_out = dout_q;
  assign pin_oe  = drive_en;
  assign int_sel = mode_q;
  assign int_lvl = sensed;

endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [BUS_ADDR_W-1:0] addr,
  input logic                  wr_en,
  input logic [BUS_DATA_W-1:0] wdata,
  input logic                  rd_en,
  input logic [BUS_DATA_W-1:0] rdata,
  input logic [PIN_COUNT-1:0]  pin_out,
  input logic [PIN_COUNT-1:0]  pin_oe,
  input logic [PIN_COUNT-1:0]  int_sel
);

  localparam logic [BUS_DATA_W-1:0] LIVE_MASK =
    (PIN_COUNT >= BUS_DATA_W) ? '1 : ((BUS_DATA_W'(1) << PIN_COUNT) - 1);

  logic mapped;
  assign mapped = (addr == OFF_MODE) || (addr == OFF_DIR) ||
                  (addr == OFF_OUT)  || (addr == OFF_POL);

  // R1: nothing is driven while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == '0 && pin_out == '0));

  // R3: a mode write of all ones removes every output enable
  a_r3_irq_mode_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_MODE && (wdata & LIVE_MASK) == LIVE_MASK)
    |=> (pin_oe == '0 && int_sel == '1));

  // R4: output levels only change after an output-data write
  a_r4_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFF_OUT) |=> $stable(pin_out));

  // R8: bits above the pin count never read as one
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~LIVE_MASK) == '0);

  // R9: writes off the map disturb no pin state
  a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(int_sel)));

  // R10: read data holds without a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .wdata   (wdata),
  .rd_en   (rd_en),
  .rdata   (rdata),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .int_sel (int_sel)
);

// File: tb/test_gpio_bank_regs.sv
`timescale 1ns/1ps
module test_gpio_bank_regs;

  localparam int NP = 6;
  localparam logic [31:0] LIVE = 32'h3F;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    addr;
  logic          wr_en;
  logic [31:0]   wdata;
  logic          rd_en;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [NP-1:0] int_sel;
  logic [NP-1:0] int_lvl;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_regs #(.PIN_COUNT(NP)) i_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .int_sel(int_sel), .int_lvl(int_lvl)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [NP-1:0] pols [3];
    logic [NP-1:0] mpat;
    pols[0] = 6'h00; pols[1] = 6'h3F; pols[2] = 6'h15;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; rd_en = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    chk(pin_oe == '0 && pin_out == '0, "R1 pins idle in reset", {pin_oe, pin_out}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: every register zero after reset
    rd_chk(8'h00, 0, "R1 mode");
    rd_chk(8'h04, 0, "R1 dir");
    rd_chk(8'h08, 0, "R1 out");
    rd_chk(8'h0C, 0, "R1 in");
    rd_chk(8'h20, 0, "R1 pol");
    chk(pin_oe == '0, "R1 oe", 32'(pin_oe), 0);

    // R2: direction sweep in plain I/O mode
    for (int d = 0; d < 64; d++) begin
      wr(8'h04, 32'(d));
      chk(pin_oe == NP'(d), "R2 oe follows dir", 32'(pin_oe), 32'(d));
    end
    // R3: interrupt-mode pins never driven
    mpat = 6'b101010;
    wr(8'h00, 32'(mpat));
    chk(int_sel == mpat, "R3 int_sel", 32'(int_sel), 32'(mpat));
    for (int d = 0; d < 64; d++) begin
      wr(8'h04, 32'(d));
      chk(pin_oe == (NP'(d) & ~mpat), "R3 oe masked by mode", 32'(pin_oe),
          32'(NP'(d) & ~mpat));
    end
    wr(8'h00, 0);
    wr(8'h04, 0);

    // R4: preload output while pin is input
    wr(8'h08, 32'h2D);
    chk(pin_out == 6'h2D && pin_oe == 0, "R4 preload drives level, no enable",
        32'({pin_oe, pin_out}), 32'h2D);
    rd_chk(8'h08, 32'h2D, "R4 out readback");
    wr(8'h04, 32'h3F);
    chk(pin_oe == 6'h3F && pin_out == 6'h2D, "R4 enable with preloaded value",
        32'({pin_oe, pin_out}), 32'hFED);
    wr(8'h04, 0);

    // R5 / R7: input sweep under three polarity masks
    for (int p = 0; p < 3; p++) begin
      wr(8'h20, 32'(pols[p]));
      rd_chk(8'h20, 32'(pols[p]), "R7 pol readback");
      for (int x = 0; x < 64; x++) begin
        @(negedge clk);
        pin_in = NP'(x);
        repeat (2) @(negedge clk);
        rd(8'h0C, v);
        chk(v == 32'(NP'(x) ^ pols[p]), "R5 R7 input xor polarity", v,
            32'(NP'(x) ^ pols[p]));
        chk(int_lvl == (NP'(x) ^ pols[p]), "R5 int_lvl", 32'(int_lvl),
            32'(NP'(x) ^ pols[p]));
      end
    end
    wr(8'h20, 0);

    // R6: mixed outputs and inputs; interrupt-mode pin reads the pad
    wr(8'h08, 32'h05);
    wr(8'h04, 32'h0F);
    @(negedge clk); pin_in = 6'h3A;
    repeat (3) @(negedge clk);
    rd_chk(8'h0C, 32'h35, "R6 outputs read driven value");
    wr(8'h00, 32'h01);
    rd_chk(8'h0C, 32'h34, "R6 interrupt pin reads pad");
    wr(8'h00, 0);

    // R8: upper bits cannot be set
    wr(8'h00, 32'hFFFF_FFC0); rd_chk(8'h00, 0, "R8 mode upper");
    wr(8'h04, 32'hFFFF_FFFF); rd_chk(8'h04, 32'h3F, "R8 dir upper");
    wr(8'h08, 32'hFFFF_FFFF); rd_chk(8'h08, 32'h3F, "R8 out upper");
    wr(8'h20, 32'hFFFF_FFFF); rd_chk(8'h20, 32'h3F, "R8 pol upper");
    wr(8'h20, 0);
    wr(8'h04, 32'h03); wr(8'h08, 32'h12);

    // R9: stray writes and reads
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd_chk(8'h00, 0, "R9 mode untouched");
    rd_chk(8'h04, 32'h03, "R9 dir untouched");
    rd_chk(8'h08, 32'h12, "R9 out untouched");
    rd_chk(8'h20, 0, "R9 pol untouched");
    chk(pin_oe == 6'h03 && pin_out == 6'h12, "R9 pins untouched",
        32'({pin_oe, pin_out}), 32'h0D2);
    rd_chk(8'h10, 0, "R9 unmapped read");
    rd_chk(8'h05, 0, "R9 misaligned read");

    // R10: read data held without a strobe
    rd_chk(8'h08, 32'h12, "R10 read");
    wr(8'h08, 32'h21);
    repeat (2) @(negedge clk);
    chk(rdata == 32'h12, "R10 rdata held", rdata, 32'h12);
    rd_chk(8'h08, 32'h21, "R10 new read");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule